// File: doc/BRIEF.md
# Banked GPIO Controller with Combined Interrupt

This block is a memory-mapped general-purpose I/O controller. Its pins are split into `NUM_BANKS` banks of `BANK_W` pins each, where `BANK_W` is between 1 and 32. Each bank has eight 32-bit registers:

- open-drain enable
- output value
- direction
- edge polarity
- any-edge select
- interrupt enable
- level mode
- event status

Software drives outputs by writing the whole output-value register. There are no set or clear shortcuts.

Pin inputs pass through a two-flop synchronizer. A register holds the previous synchronized value, and edges are found by comparing the two. Three per-pin controls select the trigger:

- **Level mode:** the event fires while the input is high.
- **Any-edge select:** the event fires on both edges.
- **Edge polarity:** it chooses between rising and falling when any-edge is off.

Events latch into a write-one-to-clear status register. The enabled status bits of all banks are ORed onto one interrupt line.

The register bus is single-cycle. A write is taken at the clock edge when `bus_wr_i` is high. Read data is a combinational function of the address.

Top module: `gpio_ctrl`

## Requirements
- R1: The byte address of a register is bank*0x20 plus its offset. Offsets: open-drain enable 0x00, output value 0x04, direction 0x08, edge polarity 0x0C, any-edge select 0x10, interrupt enable 0x14, level mode 0x18, event status 0x1C. Bit n of each register belongs to pin n of that bank.
- R2: After reset the direction register is all ones (every pin an input) and every other register reads zero. `irq_o` and `pin_oe_o` are low.
- R3: Register bits at or above `BANK_W` read as zero, store nothing and never cause an interrupt.
- R4: A pin whose direction bit is 0 is an output: `pin_oe_o` is 1 and `pin_out_o` follows its output-value bit. A direction bit of 1 makes `pin_oe_o` 0.
- R5: An output pin with its open-drain bit set drives `pin_out_o` = 0, with `pin_oe_o` equal to the inverse of its output-value bit.
- R6: Reading the output-value register returns the synchronized pin input for input pins and the stored value for output pins.
- R7: With level mode 1, the status bit is set on every cycle the synchronized input is high, so a clear while the input stays high has no lasting effect.
- R8: With level mode 0 the pin is edge-triggered. Any-edge 1 flags both edges. Otherwise edge polarity 1 flags rising edges and 0 flags falling edges.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle as a clear leaves the bit set.
- R10: `irq_o` is high exactly when some bank has a status bit whose interrupt-enable bit is 1.
- R11: An input change driven between two clock edges shows in the status register after the third following rising edge, not the second.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W-2 | Byte address bits [ADDR_W-1:2] |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data |
| pin_i | input | NUM_BANKS*BANK_W | Raw pin inputs, bank-major |
| pin_out_o | output | NUM_BANKS*BANK_W | Pin output values |
| pin_oe_o | output | NUM_BANKS*BANK_W | Pin output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a clear and a new event landing on the same status bit in the same cycle. The event is only visible internally, two edges after the pin moves.

The bench drops an any-edge pin at a known falling edge and waits for one further falling edge. It then issues the clear so that the write is captured at the third rising edge, exactly when the edge detector fires.

The level-mode re-set after a clear, and the three-edge input latency, are pinned down by sampling the status register just before and just after that edge.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned BANK_SPAN_LOG2 = 5;

  typedef enum logic [2:0] {
    SEL_OD   = 3'd0,
    SEL_OUT  = 3'd1,
    SEL_DIR  = 3'd2,
    SEL_EPOL = 3'd3,
    SEL_EANY = 3'd4,
    SEL_IEN  = 3'd5,
    SEL_LVL  = 3'd6,
    SEL_EVT  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      warm_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
      if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end
  end

  assign q_o = sync_q;

  // two edges of latency once history is valid
  assert_sync_lag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] eany_i,
  input  logic [W-1:0] epol_i,
  output logic [W-1:0] ev_o
);
  logic [W-1:0] prev_q, rise, fall, edge_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= s_i;
  end

  assign rise = s_i & ~prev_q;
  assign fall = ~s_i & prev_q;

  for (genvar i = 0; i < int'(W); i++) begin : g_pin
    always_comb begin
      if (eany_i[i])      edge_hit[i] = rise[i] | fall[i];
      else if (epol_i[i]) edge_hit[i] = rise[i];
      else                edge_hit[i] = fall[i];
    end
  end

  assign ev_o = (lvl_i & s_i) | (~lvl_i & edge_hit);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  reg_sel_e         sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic [W-1:0]     pin_i,
  output logic [W-1:0]     pin_out_o,
  output logic [W-1:0]     pin_oe_o,
  output logic             irq_o
);
  logic [W-1:0] od_q, out_q, dir_q, epol_q, eany_q, ien_q, lvl_q, evt_q;
  logic [W-1:0] pin_s, ev, clr, evt_d, wd;

  assign wd = wdata_i[W-1:0];

  gpio_sync #(.W(W)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_s)
  );

  gpio_evt_detect #(.W(W)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .s_i(pin_s),
    .lvl_i(lvl_q), .eany_i(eany_q), .epol_i(epol_q), .ev_o(ev)
  );

  assign clr   = (we_i && sel_i == SEL_EVT) ? wd : '0;
  assign evt_d = (evt_q & ~clr) | ev;   // event beats clear

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      od_q   <= '0;
      out_q  <= '0;
      dir_q  <= '1;
      epol_q <= '0;
      eany_q <= '0;
      ien_q  <= '0;
      lvl_q  <= '0;
      evt_q  <= '0;
    end else begin
      evt_q <= evt_d;
      if (we_i) begin
        unique case (sel_i)
          SEL_OD:   od_q   <= wd;
          SEL_OUT:  out_q  <= wd;
          SEL_DIR:  dir_q  <= wd;
          SEL_EPOL: epol_q <= wd;
          SEL_EANY: eany_q <= wd;
          SEL_IEN:  ien_q  <= wd;
          SEL_LVL:  lvl_q  <= wd;
          SEL_EVT:  ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_OD:   rdata_o = REG_W'(od_q);
      SEL_OUT:  rdata_o = REG_W'((out_q & ~dir_q) | (pin_s & dir_q));
      SEL_DIR:  rdata_o = REG_W'(dir_q);
      SEL_EPOL: rdata_o = REG_W'(epol_q);
      SEL_EANY: rdata_o = REG_W'(eany_q);
      SEL_IEN:  rdata_o = REG_W'(ien_q);
      SEL_LVL:  rdata_o = REG_W'(lvl_q);
      SEL_EVT:  rdata_o = REG_W'(evt_q);
    endcase
  end

  assign pin_out_o = out_q & ~od_q;
  assign pin_oe_o  = ~dir_q & (~od_q | ~out_q);
  assign irq_o     = |(evt_q & ien_q);

  assert_evt_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev) |=> ((evt_q & $past(ev)) == $past(ev)));

  assert_w1c_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_EVT) |=> ((evt_q & $past(wd & ~ev)) == '0));

  assert_no_spurious_evt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_q & ~$past(evt_q) & ~$past(ev)) == '0));
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_W    = 20,
  parameter int unsigned ADDR_W    = BANK_SPAN_LOG2 + $clog2(NUM_BANKS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_wr_i,
  input  logic [ADDR_W-1:2]           bus_addr_i,
  input  logic [REG_W-1:0]            bus_wdata_i,
  output logic [REG_W-1:0]            bus_rdata_o,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_i,
  output logic [NUM_BANKS*BANK_W-1:0] pin_out_o,
  output logic [NUM_BANKS*BANK_W-1:0] pin_oe_o,
  output logic                        irq_o
);
  localparam int unsigned SEL_SHIFT = BANK_SPAN_LOG2 - 2;

  logic [31:0]      bank_idx;
  reg_sel_e         sel;
  logic [REG_W-1:0] bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_irq;

  assign bank_idx = 32'(bus_addr_i) >> SEL_SHIFT;
  assign sel      = reg_sel_e'(bus_addr_i[4:2]);

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
    gpio_bank #(.W(BANK_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (bus_wr_i && bank_idx == 32'(b)),
      .sel_i    (sel),
      .wdata_i  (bus_wdata_i),
      .rdata_o  (bank_rd[b]),
      .pin_i    (pin_i[b*BANK_W +: BANK_W]),
      .pin_out_o(pin_out_o[b*BANK_W +: BANK_W]),
      .pin_oe_o (pin_oe_o[b*BANK_W +: BANK_W]),
      .irq_o    (bank_irq[b])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++)
      if (bank_idx == 32'(b)) bus_rdata_o = bank_rd[b];
  end

  assign irq_o = |bank_irq;
endmodule

// File: tb/gpio_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_ctrl_tb_top;
  localparam int NB = 2;
  localparam int BW = 20;
  localparam int AW = 5 + $clog2(NB);
  localparam logic [31:0] WMASK = (32'h1 << BW) - 1;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [AW-1:2] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NB*BW-1:0] pins = '0, pin_out, pin_oe;
  logic irq;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  gpio_ctrl #(.NUM_BANKS(NB), .BANK_W(BW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .pin_i(pins),
    .pin_out_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int bank, input int off, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = AW'((bank * 32 + off) >> 2); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int bank, input int off, output logic [31:0] v);
    bus_addr = AW'((bank * 32 + off) >> 2);
    #1 v = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int b = 0; b < NB; b++)
      for (int o = 0; o < 32; o += 4) begin
        rd(b, o, v);
        chk("R2 reset regs", v, (o == 8) ? WMASK : 32'h0);
      end
    chk("R2 reset irq", 32'(irq), 0);
    chk("R2 reset oe", 32'(|pin_oe), 0);
  endtask

  task automatic t_map_width();
    logic [31:0] v;
    wr(1, 'h14, 32'hFFFF_FFFF);
    rd(1, 'h14, v); chk("R3 upper bits zero", v, WMASK);
    wr(0, 'h18, 32'h0000_00A5);
    rd(0, 'h18, v); chk("R1 bank0 level offset", v, 32'hA5);
    rd(1, 'h18, v); chk("R1 bank1 level untouched", v, 0);
    rd(0, 'h14, v); chk("R1 bank0 enable untouched", v, 0);
    wr(1, 'h14, 0);
    wr(0, 'h18, 0);
  endtask

  task automatic t_output();
    logic [31:0] v;
    wr(0, 'h08, 32'hFFFF_FFF0);
    wr(0, 'h04, 32'h5);
    #1;
    chk("R4 out value", 32'(pin_out[3:0]), 32'h5);
    chk("R4 out enable", 32'(pin_oe[4:0]), 32'hF);
    wr(0, 'h00, 32'h3);
    #1;
    chk("R5 open-drain out", 32'(pin_out[3:0]), 32'h4);
    chk("R5 open-drain oe", 32'(pin_oe[3:0]), 32'hE);
    wr(0, 'h00, 0);
    @(negedge clk); pins[5] = 1;
    repeat (3) @(negedge clk);
    rd(0, 'h04, v); chk("R6 data readback", v, 32'h25);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    wr(1, 'h10, 32'h1);
    wr(1, 'h0C, 32'h2);
    wr(1, 'h14, 32'h7);
    @(negedge clk); pins[BW +: 3] = 3'b111;
    @(posedge clk); @(posedge clk); #1;
    rd(1, 'h1C, v); chk("R11 not yet after two edges", v, 0);
    @(posedge clk); #1;
    rd(1, 'h1C, v); chk("R8 rising: any+rise", v, 32'h3);
    chk("R10 irq on enabled evt", 32'(irq), 1);
    wr(1, 'h1C, 32'h7);
    rd(1, 'h1C, v); chk("R9 w1c clears", v, 0);
    chk("R10 irq drops", 32'(irq), 0);
    @(negedge clk); pins[BW +: 3] = 3'b000;
    repeat (4) @(negedge clk);
    rd(1, 'h1C, v); chk("R8 falling: any+fall", v, 32'h5);
    wr(1, 'h1C, 32'h7);
    wr(1, 'h14, 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(0, 'h18, 32'h400);
    wr(0, 'h14, 32'h400);
    @(negedge clk); pins[10] = 1;
    repeat (4) @(negedge clk);
    rd(0, 'h1C, v); chk("R7 level sets", v & 32'h400, 32'h400);
    chk("R10 level irq", 32'(irq), 1);
    wr(0, 'h1C, 32'h400);
    rd(0, 'h1C, v); chk("R7 level re-sets after clear", v & 32'h400, 32'h400);
    @(negedge clk); pins[10] = 0;
    repeat (4) @(negedge clk);
    wr(0, 'h1C, 32'h400);
    rd(0, 'h1C, v); chk("R7 clear sticks once low", v & 32'h400, 0);
    chk("R10 irq low", 32'(irq), 0);
    wr(0, 'h18, 0);
  endtask

  task automatic t_conflict();
    logic [31:0] v;
    wr(0, 'h14, 0);
    wr(0, 'h10, 32'h800);
    @(negedge clk); pins[11] = 1;
    repeat (4) @(negedge clk);
    rd(0, 'h1C, v); chk("R8 any-edge rise", v, 32'h800);
    chk("R10 masked evt no irq", 32'(irq), 0);
    wr(0, 'h14, 32'h800);
    #1 chk("R10 enable raises irq", 32'(irq), 1);
    wr(0, 'h1C, 32'h0);
    rd(0, 'h1C, v); chk("R9 write zero keeps", v, 32'h800);
    @(negedge clk); pins[11] = 0;
    @(negedge clk);
    wr(0, 'h1C, 32'h800);   // captured on the edge the fall is detected
    rd(0, 'h1C, v); chk("R9 event wins over clear", v, 32'h800);
    wr(0, 'h1C, 32'h800);
    rd(0, 'h1C, v); chk("R9 later clear works", v, 0);
    wr(0, 'h14, 0);
  endtask

  task automatic t_upper();
    logic [31:0] v;
    wr(1, 'h14, 32'hFFFF_FFFF);
    wr(1, 'h18, 32'hFFF0_0000);
    rd(1, 'h18, v); chk("R3 level upper zero", v, 0);
    repeat (3) @(negedge clk);
    chk("R3 no irq from upper bits", 32'(irq), 0);
    rd(1, 'h1C, v); chk("R3 status upper zero", v, 0);
  endtask

  initial begin
    #100_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_map_width();
    t_output();
    t_edges();
    t_level();
    t_conflict();
    t_upper();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule